// File: doc/BRIEF.md
# Serial Status-Register Write-Protect Controller

This block sits on the slave side of the serial command port of a 64-Kbit serial memory. It watches the chip-select, serial clock and serial data pins. When a complete status-write frame arrives, it updates three non-volatile protection bits: a hardware-lock enable bit and a two-bit array protection level. The pins are brought into the system clock domain through synchronizer chains. The frame is then decoded with edge detection on the synchronized serial clock.

The held protection bits do two jobs. First, together with the active-low write-protect pin, they decide whether a later status write may land at all. Second, they drive a combinational decode that marks a queried array address as protected or writable. Any complete status-write frame produces a one-cycle pulse that tells the surrounding logic to clear its write-enable latch, whether or not the write was allowed.

Non-volatile storage is not modelled. Instead, a load port preloads the held bits, for example after power-up.

Top module: `spi_status_guard`

## Requirements
- R1: A status write is a frame with chip select (`cs_n`) low, carrying the opcode 8'h01 followed by 8 data bits. Bits arrive MSB first and are sampled on each rising edge of `sck`. The write commits only when `cs_n` rises after exactly 16 rising `sck` edges. The new status is visible on `status` within 8 `clk` cycles of that rise.
- R2: A frame is discarded without changing `status` and without a `wel_clr` pulse if it has 15 or 17 clocks, or if its opcode is anything other than 8'h01.
- R3: The status field layout is fixed: the hardware-lock enable is bit 7, the upper protect-level bit is bit 3 and the lower protect-level bit is bit 2. Every other bit reads as 0 and cannot be written by a frame or by a load.
- R4: A complete status-write frame changes `status` only while `wel` is 1. With `wel` at 0, `status` is left unchanged.
- R5: Every complete status-write frame, whether accepted or refused, produces exactly one `wel_clr` pulse lasting one `clk` cycle.
- R6: Hardware lock is active when `wp_n` is 0 and status bit 7 is 1. While it is active, a status-write frame leaves `status` unchanged. When `wp_n` is 1 or bit 7 is 0, the frame is accepted (given `wel` is 1).
- R7: With protect level 2'b00 (status bits 3:2), `addr_prot` is 0 for every address.
- R8: With protect level 2'b01, `addr_prot` is 1 exactly for addresses 1800h to 1FFFh.
- R9: With protect level 2'b10, `addr_prot` is 1 exactly for addresses 1000h to 1FFFh. With level 2'b11, it is 1 for every address.
- R10: Only bits 12:0 of `query_addr` are decoded; bits 15:13 have no effect on `addr_prot`.
- R11: `so_oe` stays 0 at all times, including throughout a status-write frame, so the serial output remains high impedance.
- R12: Reset sets `status` to 8'h00. A one-cycle pulse on `load_en` writes `load_val`, masked to bits 7, 3 and 2, into `status` on the next `clk` edge, regardless of `wp_n` and `wel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low (asynchronous pin) |
| sck | input | 1 | Serial clock (asynchronous pin) |
| si | input | 1 | Serial data in (asynchronous pin) |
| wp_n | input | 1 | Write-protect pin, active low, sampled on clk |
| wel | input | 1 | Write-enable latch flag from the command logic |
| load_en | input | 1 | Preload strobe for the held status bits |
| load_val | input | 8 | Preload value |
| query_addr | input | 16 | Array address whose protection is queried |
| status | output | 8 | Held status byte |
| addr_prot | output | 1 | Queried address is write protected |
| so_oe | output | 1 | Serial-out drive enable |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The assertions assume a few things about the inputs. `wp_n`, `wel` and `load_en` must be synchronous to `clk`. `load_en` must not coincide with the end of a frame. The serial pins must change slowly enough that each `sck` level lasts several `clk` cycles after synchronization. The stimulus meets these conditions. It holds each `sck` phase for four `clk` cycles and changes `si` only while `sck` is low. It changes `wp_n` and `wel` only between frames, and it issues loads only while `cs_n` is high and the previous commit has settled. Under these conditions, any change of `status` can be traced to either a load or a one-cycle `wel_clr` pulse.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

  localparam int STAT_W   = 8;
  localparam int LOCK_POS = 7;
  localparam int LVL_HI   = 3;
  localparam int LVL_LO   = 2;
  localparam logic [STAT_W-1:0] STAT_MASK = 8'h8C;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_level_e;

  typedef struct packed {
    logic        lock_en;
    prot_level_e level;
  } prot_bits_t;

  function automatic prot_bits_t unpack_status(input logic [STAT_W-1:0] v);
    prot_bits_t p;
    p.lock_en = v[LOCK_POS];
    p.level   = prot_level_e'({v[LVL_HI], v[LVL_LO]});
    return p;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input prot_bits_t p);
    logic [STAT_W-1:0] v;
    v           = '0;
    v[LOCK_POS] = p.lock_en;
    v[LVL_HI]   = p.level[1];
    v[LVL_LO]   = p.level[0];
    return v;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int               OP_W   = 8,
  parameter int               DATA_W = 8,
  parameter logic [OP_W-1:0]  OPCODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              si_s,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data
);

  localparam int FRAME_BITS = OP_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  logic                  sck_q;
  logic                  cs_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      cnt;
  logic                  sck_rise;
  logic                  cs_rise;
  logic                  op_match;

  assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_q;
  assign op_match = (shreg[FRAME_BITS-1 -: OP_W] == OPCODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      shreg      <= '0;
      cnt        <= '0;
      frame_done <= 1'b0;
      frame_data <= '0;
    end else begin
      sck_q      <= sck_s;
      cs_q       <= cs_n_s;
      frame_done <= cs_rise && (cnt == CNT_FULL) && op_match;
      if (cs_rise) frame_data <= shreg[DATA_W-1:0];
      if (cs_n_s) begin
        cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], si_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/prot_status_reg.sv
module prot_status_reg
  import spi_guard_pkg::*;
#(
  parameter logic [STAT_W-1:0] INIT_STATUS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [STAT_W-1:0] load_val,
  input  logic              frame_done,
  input  logic [STAT_W-1:0] frame_data,
  input  logic              wel,
  input  logic              wp_n,
  output prot_bits_t        bits,
  output logic              wel_clr
);

  logic hw_lock;
  logic accept;

  assign hw_lock = ~wp_n & bits.lock_en;
  assign accept  = frame_done & wel & ~hw_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits    <= unpack_status(INIT_STATUS);
      wel_clr <= 1'b0;
    end else begin
      wel_clr <= frame_done;
      if (load_en)     bits <= unpack_status(load_val);
      else if (accept) bits <= unpack_status(frame_data);
    end
  end

endmodule

// File: rtl/addr_prot_decode.sv
module addr_prot_decode
  import spi_guard_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int QADDR_W = 16
) (
  input  logic [QADDR_W-1:0] query_addr,
  input  prot_level_e        level,
  output logic               hit
);

  logic [ADDR_W-1:0] a;
  assign a = query_addr[ADDR_W-1:0];

  always_comb begin
    unique case (level)
      LVL_NONE:    hit = 1'b0;
      LVL_QUARTER: hit = &a[ADDR_W-1 -: 2];
      LVL_HALF:    hit = a[ADDR_W-1];
      default:     hit = 1'b1;
    endcase
  end

  if (QADDR_W > ADDR_W) begin : g_upper
    logic [QADDR_W-ADDR_W-1:0] unused_hi;
    assign unused_hi = query_addr[QADDR_W-1:ADDR_W];
  end

endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
  import spi_guard_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 13,
  parameter int                QADDR_W     = 16,
  parameter logic [7:0]        OPCODE_WR   = 8'h01,
  parameter logic [STAT_W-1:0] INIT_STATUS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              wp_n,
  input  logic              wel,
  input  logic              load_en,
  input  logic [STAT_W-1:0] load_val,
  input  logic [QADDR_W-1:0] query_addr,
  output logic [STAT_W-1:0] status,
  output logic              addr_prot,
  output logic              so_oe,
  output logic              wel_clr
);

  logic [2:0]        pins_s;
  logic              frame_done;
  logic [STAT_W-1:0] frame_data;
  prot_bits_t        bits;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, si}),
    .q   (pins_s)
  );

  spi_frame_shifter #(.OP_W(8), .DATA_W(STAT_W), .OPCODE(OPCODE_WR)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .cs_n_s     (pins_s[2]),
    .sck_s      (pins_s[1]),
    .si_s       (pins_s[0]),
    .frame_done (frame_done),
    .frame_data (frame_data)
  );

  prot_status_reg #(.INIT_STATUS(INIT_STATUS)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .load_val   (load_val),
    .frame_done (frame_done),
    .frame_data (frame_data),
    .wel        (wel),
    .wp_n       (wp_n),
    .bits       (bits),
    .wel_clr    (wel_clr)
  );

  addr_prot_decode #(.ADDR_W(ADDR_W), .QADDR_W(QADDR_W)) u_dec (
    .query_addr (query_addr),
    .level      (bits.level),
    .hit        (addr_prot)
  );

  assign status = pack_status(bits);

  // This block only accepts writes, so it never drives the serial output.
  always_ff @(posedge clk) begin
    if (rst) so_oe <= 1'b0;
    else     so_oe <= 1'b0;
  end

endmodule

// File: rtl/spi_status_guard_chk.sv
module spi_status_guard_chk (
  input logic        clk,
  input logic        rst,
  input logic        wp_n,
  input logic        wel,
  input logic        load_en,
  input logic [7:0]  status,
  input logic        addr_prot,
  input logic        so_oe,
  input logic        wel_clr
);

  // R3: bits outside 7, 3, 2 always read as zero
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (status & 8'h73) == 8'h00);

  // R5: the latch-clear request lasts one cycle
  assert_clr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    wel_clr |=> !wel_clr);

  // status moves only on a load or a completed frame
  assert_change_source_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_en) && !wel_clr) |-> $stable(status));

  // R4: refused when the enable latch was clear
  assert_wel_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (wel_clr && !$past(wel) && !$past(load_en)) |-> $stable(status));

  // R6: hardware lock freezes the status byte
  assert_hw_lock_R6: assert property (@(posedge clk) disable iff (rst)
    (wel_clr && !$past(wp_n) && $past(status[7]) && !$past(load_en)) |-> $stable(status));

  // R7 / R9: extreme protect levels
  assert_level_none_R7: assert property (@(posedge clk) disable iff (rst)
    (status[3:2] == 2'b00) |-> !addr_prot);
  assert_level_all_R9: assert property (@(posedge clk) disable iff (rst)
    (status[3:2] == 2'b11) |-> addr_prot);

  // R11: serial output never driven
  assert_so_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !so_oe);

endmodule

bind spi_status_guard spi_status_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wp_n      (wp_n),
  .wel       (wel),
  .load_en   (load_en),
  .status    (status),
  .addr_prot (addr_prot),
  .so_oe     (so_oe),
  .wel_clr   (wel_clr)
);

// File: tb/tb_spi_status_guard.sv
`timescale 1ns/1ps
module tb_spi_status_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic        wp_n = 1'b1, wel = 1'b0, load_en = 1'b0;
  logic [7:0]  load_val = '0;
  logic [15:0] query_addr = '0;
  logic [7:0]  status;
  logic        addr_prot, so_oe, wel_clr;

  always #4 clk = ~clk;

  spi_status_guard dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .wel(wel), .load_en(load_en), .load_val(load_val), .query_addr(query_addr),
    .status(status), .addr_prot(addr_prot), .so_oe(so_oe), .wel_clr(wel_clr)
  );

  int     n_checks = 0, n_errors = 0;
  int     cyc = 0, quiet_until = 1000000;
  int     clr_seen = 0, clr_exp = 0;
  logic [7:0] exp_status = 8'h00;
  bit     finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_prot(input logic [15:0] qa, input logic [7:0] st);
    int a;
    a = int'(qa) % 8192;
    case (st[3:2])
      2'b00:   return 1'b0;
      2'b01:   return a >= 'h1800;
      2'b10:   return a >= 'h1000;
      default: return 1'b1;
    endcase
  endfunction

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (wel_clr) clr_seen++;
      check(so_oe == 1'b0, "R11 so_oe", so_oe, 0);
      if (cyc > quiet_until) begin
        check(status == exp_status, "R1 status track", status, exp_status);
        check(addr_prot == model_prot(query_addr, exp_status), "R10 addr track",
              addr_prot, model_prot(query_addr, exp_status));
      end
    end
  end

  task automatic do_load(input logic [7:0] v);
    load_en  = 1'b1;
    load_val = v;
    quiet_until = cyc + 3;
    @(negedge clk);
    load_en = 1'b0;
    exp_status = v & 8'h8C;
    @(negedge clk);
  endtask

  task automatic spi_frame(input int nbits, input logic [31:0] bits);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      si = bits[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    if (nbits == 16 && bits[15:8] == 8'h01) begin
      clr_exp++;
      if (wel && !(!wp_n && exp_status[7])) exp_status = bits[7:0] & 8'h8C;
    end
    quiet_until = cyc + 8;
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    logic [15:0] pts [10];
    pts = '{16'h0000, 16'h0FFF, 16'h1000, 16'h17FF, 16'h1800, 16'h1FFF,
            16'h2000, 16'h3800, 16'hF7FF, 16'hFFFF};
    foreach (pts[i]) begin
      query_addr = pts[i];
      #1;
      check(addr_prot == model_prot(pts[i], exp_status), tag, addr_prot,
            model_prot(pts[i], exp_status));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(status == 8'h00, "R12 reset status", status, 0);
    check(so_oe == 1'b0, "R11 reset so_oe", so_oe, 0);
    quiet_until = cyc;

    do_load(8'hFF);
    check(status == 8'h8C, "R3 load mask", status, 8'h8C);
    do_load(8'h00);
    check(status == 8'h00, "R12 load zero", status, 0);

    wel = 1'b1;
    spi_frame(16, {8'h01, 8'hFF});
    check(status == 8'h8C, "R1 write accepted", status, 8'h8C);
    check(clr_seen == clr_exp, "R5 clr count", clr_seen, clr_exp);
    spi_frame(16, {8'h01, 8'h04});
    check(status == 8'h04, "R3 field bits", status, 8'h04);

    wel = 1'b0;
    spi_frame(16, {8'h01, 8'h08});
    check(status == 8'h04, "R4 wel low", status, 8'h04);
    check(clr_seen == clr_exp, "R5 clr on refused", clr_seen, clr_exp);

    wel = 1'b1;
    spi_frame(15, {8'h01, 7'h04});
    check(status == 8'h04, "R2 15 clocks", status, 8'h04);
    spi_frame(17, {8'h01, 8'h08, 1'b0});
    check(status == 8'h04, "R2 17 clocks", status, 8'h04);
    spi_frame(16, {8'h02, 8'h08});
    check(status == 8'h04, "R2 bad opcode", status, 8'h04);
    check(clr_seen == clr_exp, "R2 no clr", clr_seen, clr_exp);

    spi_frame(16, {8'h01, 8'h88});
    check(status == 8'h88, "R6 lock set", status, 8'h88);
    wp_n = 1'b0;
    spi_frame(16, {8'h01, 8'h00});
    check(status == 8'h88, "R6 locked", status, 8'h88);
    check(clr_seen == clr_exp, "R5 clr when locked", clr_seen, clr_exp);
    wp_n = 1'b1;
    spi_frame(16, {8'h01, 8'h80});
    check(status == 8'h80, "R6 pin high", status, 8'h80);
    do_load(8'h04);
    wp_n = 1'b0;
    spi_frame(16, {8'h01, 8'h08});
    check(status == 8'h08, "R6 enable clear", status, 8'h08);
    wp_n = 1'b1;

    do_load(8'h00); sweep("R7 level none");
    do_load(8'h04); sweep("R8 level quarter");
    do_load(8'h08); sweep("R9 level half");
    do_load(8'h0C); sweep("R9 level all");
    do_load(8'h04);
    query_addr = 16'hF800; #1;
    check(addr_prot == 1'b1, "R10 upper bits", addr_prot, 1);
    query_addr = 16'hE7FF; #1;
    check(addr_prot == 1'b0, "R10 upper bits", addr_prot, 0);

    check(clr_seen == clr_exp, "R5 final clr", clr_seen, clr_exp);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule